// File: doc/BRIEF.md
# Bridge Read Prefetch Buffer

This block sits inside a bridge on the read path between a requesting master and a downstream memory target. It accepts one read transaction at a time. The transaction carries a command, a DWORD address and byte enables. The block then issues DWORD reads downstream and returns the data to the master in address order, one DWORD per read strobe. How far it reads ahead depends on the command:

- A single read never reads ahead, because the location may have side effects.
- A line read fills the buffer up to the end of the current cacheline.
- A multiple read keeps streaming past the line boundary, within a window of a few lines.

Whenever a transaction ends, everything still buffered is discarded, together with every downstream response still in flight for it. A later read therefore cannot see stale data.

The cacheline size comes from a configuration input, as a power of two in DWORDs. The buffer depth and the extra lookahead for multiple reads are parameters. Downstream responses return in request order.

Top module: `rdpf_bridge`

## Requirements
- R1: A single read (command 2'b00) issues exactly one downstream read, at the requested address and with the requested byte enables. The returned DWORD carries those same enables on `m_be`.
- R2: A single read delivers exactly one DWORD, and `m_last` is high with it. No further downstream read or data follows while the transaction stays open.
- R3: A line read (command 2'b01) fetches consecutive addresses from the requested DWORD up to the last DWORD of its line. The line holds 2^min(`cfg_line_log2`, MAX_LINE_LOG2) DWORDs, so a request at offset k fetches (line − k) DWORDs. `m_last` marks the final one.
- R4: A multiple read (command 2'b10) continues past the line boundary without limit. It keeps the number of fetched but unconsumed DWORDs below min(DEPTH, line × (1 + MULTI_EXTRA_LINES)), and `m_last` stays low.
- R5: Line and multiple reads request all four bytes downstream (`ds_req_be` = 4'b1111) and report `m_be` = 4'b1111 whatever `req_be` was.
- R6: The count of DWORDs requested downstream but not yet consumed never exceeds DEPTH. Issue stops at that limit and resumes as the master drains the buffer.
- R7: `m_data` presents the downstream data of consecutive addresses starting at the requested address, in that order. A read strobe advances the buffer only while `m_valid` is high.
- R8: Transaction end (`txn_end` while a transaction is open) clears `m_valid` from the next cycle. It stops downstream requests, and data left from that transaction is never delivered.
- R9: Downstream responses to reads issued before a transaction ended are discarded. The next transaction delivers only its own data.
- R10: After reset, `m_valid`, `m_last` and `ds_req_valid` are low.
- R11: A request presented while a transaction is open has no effect on the addresses fetched or the data returned.
- R12: The reserved command 2'b11 starts no transaction and issues nothing. A `txn_end` with no open transaction has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start of a read transaction |
| req_cmd | input | 2 | 00 single, 01 line, 10 multiple, 11 reserved |
| req_addr | input | AW | Starting DWORD address |
| req_be | input | 4 | Byte enables, active high |
| rd_strobe | input | 1 | Master consumes the presented DWORD |
| txn_end | input | 1 | Master ends the transaction |
| cfg_line_log2 | input | LW | Cacheline size as log2 of DWORDs |
| m_valid | output | 1 | Head DWORD is valid |
| m_data | output | DATA_W | Head DWORD |
| m_be | output | 4 | Valid bytes of the head DWORD |
| m_last | output | 1 | Head DWORD is the final one of the transaction |
| ds_req_valid | output | 1 | Downstream read request |
| ds_req_ready | input | 1 | Downstream accepts the request |
| ds_req_addr | output | AW | Downstream DWORD address |
| ds_req_be | output | 4 | Downstream byte enables |
| ds_rsp_valid | input | 1 | Downstream response, in request order |
| ds_rsp_data | input | DATA_W | Downstream response data |

## Verification
The bench builds the block with DEPTH 8, MAX_LINE_LOG2 4 and one extra lookahead line, then varies `cfg_line_log2` between transactions:

- A 16-DWORD line is larger than the buffer, which exercises stall and resume on a line read.
- A 2-DWORD line makes the multiple-read window (4) smaller than the buffer, which separates that window from the depth limit.
- A 4-DWORD line makes the window and the depth limit equal.

A downstream model with selectable latency and ready gaps keeps responses in flight across a transaction end. Reads of the same addresses under new memory contents then expose any stale delivery.

// File: rtl/rdpf_pkg.sv
package rdpf_pkg;
  typedef enum logic [1:0] {
    RD_SINGLE = 2'b00,
    RD_LINE   = 2'b01,
    RD_MULTI  = 2'b10,
    RD_RSVD   = 2'b11
  } rd_cmd_e;
endpackage

// File: rtl/rdpf_fifo.sv
module rdpf_fifo #(
  parameter  int DW    = 32,
  parameter  int DEPTH = 8,
  localparam int PW    = $clog2(DEPTH),
  localparam int FW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  input  logic          flush,
  output logic [DW-1:0] rdata,
  output logic [FW-1:0] count
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [FW-1:0] cnt_q, cnt_n;
  logic          wr_en;

  // next state: flush wins over push and pop
  always_comb begin
    wr_en = push && !flush;
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (push) wp_n = wp_q + PW'(1);
      if (pop)  rp_n = rp_q + PW'(1);
      cnt_n = cnt_q + FW'(push) - FW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  // storage carries no reset; occupancy guards every read
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wp_q] <= wdata;
  end

  assign rdata = mem_q[rp_q];
  assign count = cnt_q;

  // R6: the issue credit upstream must never let a push meet a full buffer
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cnt_q < FW'(DEPTH)));
  // R8: a flush leaves nothing behind
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
endmodule

// File: rtl/rdpf_fetch_ctl.sv
module rdpf_fetch_ctl import rdpf_pkg::*; #(
  parameter  int AW                = 30,
  parameter  int DEPTH             = 8,
  parameter  int MAX_LINE_LOG2     = 4,
  parameter  int MULTI_EXTRA_LINES = 1,
  localparam int LW = $clog2(MAX_LINE_LOG2 + 1),
  localparam int CW = MAX_LINE_LOG2 + 1,
  localparam int FW = $clog2(DEPTH + 1),
  localparam int OW = $clog2(2 * DEPTH + 1),
  localparam int SW = OW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_cmd,
  input  logic [AW-1:0] req_addr,
  input  logic [3:0]    req_be,
  input  logic          txn_end,
  input  logic [LW-1:0] cfg_line_log2,
  input  logic [FW-1:0] fifo_count,
  input  logic          ds_req_ready,
  input  logic          ds_rsp_valid,
  output logic          ds_req_valid,
  output logic [AW-1:0] ds_req_addr,
  output logic [3:0]    ds_req_be,
  output logic          rsp_push,
  output logic          txn_active,
  output logic          issue_done
);
  logic          act_q, act_n, unb_q, unb_n, single_q, single_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [CW-1:0] left_q, left_n;
  logic [FW-1:0] lim_q, lim_n;
  logic [3:0]    be_q, be_n;
  logic [OW-1:0] total_q, total_n, drop_q, drop_n, live_out;
  logic [SW-1:0] occ;
  logic [LW-1:0] line_log2_eff;
  logic [CW-1:0] line_dw, offs, line_rem;
  logic [31:0]   win_w;
  logic          can_issue, fire, end_hit, start, rsp_drop;

  // request decode: line geometry and lookahead window
  always_comb begin
    line_log2_eff = (cfg_line_log2 > LW'(MAX_LINE_LOG2)) ? LW'(MAX_LINE_LOG2) : cfg_line_log2;
    line_dw  = CW'(1) << line_log2_eff;
    offs     = req_addr[CW-1:0] & (line_dw - CW'(1));
    line_rem = line_dw - offs;
    win_w    = 32'(line_dw) * 32'(MULTI_EXTRA_LINES + 1);
  end

  // issue credit and response accounting
  always_comb begin
    live_out  = total_q - drop_q;
    occ       = SW'(live_out) + SW'(fifo_count);
    can_issue = act_q && (unb_q || (left_q != '0)) && (occ < SW'(lim_q))
                && (total_q < OW'(2 * DEPTH));
    fire      = can_issue && ds_req_ready;
    end_hit   = txn_end && act_q;
    start     = req_valid && !act_q && (req_cmd != RD_RSVD);
    rsp_drop  = ds_rsp_valid && (drop_q != '0);
    rsp_push  = ds_rsp_valid && !rsp_drop && !end_hit;
    total_n   = total_q + OW'(fire) - OW'(ds_rsp_valid);
    drop_n    = end_hit ? total_n : (drop_q - OW'(rsp_drop));
  end

  // transaction state
  always_comb begin
    act_n    = act_q;
    unb_n    = unb_q;
    single_n = single_q;
    addr_n   = addr_q;
    left_n   = left_q;
    lim_n    = lim_q;
    be_n     = be_q;
    if (start) begin
      act_n    = 1'b1;
      unb_n    = (req_cmd == RD_MULTI);
      single_n = (req_cmd == RD_SINGLE);
      addr_n   = req_addr;
      left_n   = (req_cmd == RD_SINGLE) ? CW'(1) : line_rem;
      be_n     = (req_cmd == RD_SINGLE) ? req_be : 4'hF;
      lim_n    = ((req_cmd == RD_MULTI) && (win_w < 32'(DEPTH))) ? FW'(win_w) : FW'(DEPTH);
    end else begin
      if (fire) addr_n = addr_q + AW'(1);
      if (fire && !unb_q) left_n = left_q - CW'(1);
      if (end_hit) act_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      unb_q    <= 1'b0;
      single_q <= 1'b0;
      addr_q   <= '0;
      left_q   <= '0;
      lim_q    <= '0;
      be_q     <= '0;
      total_q  <= '0;
      drop_q   <= '0;
    end else begin
      act_q    <= act_n;
      unb_q    <= unb_n;
      single_q <= single_n;
      addr_q   <= addr_n;
      left_q   <= left_n;
      lim_q    <= lim_n;
      be_q     <= be_n;
      total_q  <= total_n;
      drop_q   <= drop_n;
    end
  end

  assign ds_req_valid = can_issue;
  assign ds_req_addr  = addr_q;
  assign ds_req_be    = be_q;
  assign txn_active   = act_q;
  assign issue_done   = !unb_q && (left_q == '0) && (live_out == '0);

  // R6: buffered plus in-flight live data stays within the buffer
  a_r6_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= SW'(DEPTH));
  // R2: a single read issues once and then goes quiet
  a_r2_single_once: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && single_q) |=> !ds_req_valid);
  // R4: a pending request holds its address until taken or the transaction ends
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_req_valid && !ds_req_ready && !end_hit) |=> (ds_req_valid && $stable(ds_req_addr)));
  // R9: responses owed to ended transactions are a subset of all in flight
  a_r9_drop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q <= total_q);
endmodule

// File: rtl/rdpf_bridge.sv
module rdpf_bridge import rdpf_pkg::*; #(
  parameter  int AW                = 30,
  parameter  int DATA_W            = 32,
  parameter  int DEPTH             = 8,
  parameter  int MAX_LINE_LOG2     = 4,
  parameter  int MULTI_EXTRA_LINES = 1,
  localparam int LW = $clog2(MAX_LINE_LOG2 + 1),
  localparam int FW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_cmd,
  input  logic [AW-1:0]     req_addr,
  input  logic [3:0]        req_be,
  input  logic              rd_strobe,
  input  logic              txn_end,
  input  logic [LW-1:0]     cfg_line_log2,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  output logic [3:0]        m_be,
  output logic              m_last,
  output logic              ds_req_valid,
  input  logic              ds_req_ready,
  output logic [AW-1:0]     ds_req_addr,
  output logic [3:0]        ds_req_be,
  input  logic              ds_rsp_valid,
  input  logic [DATA_W-1:0] ds_rsp_data
);
  logic [FW-1:0] fifo_count;
  logic [3:0]    be_w;
  logic          rsp_push, txn_active, issue_done, pop, flush;

  rdpf_fetch_ctl #(
    .AW(AW), .DEPTH(DEPTH), .MAX_LINE_LOG2(MAX_LINE_LOG2),
    .MULTI_EXTRA_LINES(MULTI_EXTRA_LINES)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_be(req_be), .txn_end(txn_end),
    .cfg_line_log2(cfg_line_log2), .fifo_count(fifo_count),
    .ds_req_ready(ds_req_ready), .ds_rsp_valid(ds_rsp_valid),
    .ds_req_valid(ds_req_valid), .ds_req_addr(ds_req_addr), .ds_req_be(be_w),
    .rsp_push(rsp_push), .txn_active(txn_active), .issue_done(issue_done)
  );

  assign flush = txn_end && txn_active;
  assign pop   = rd_strobe && m_valid;

  rdpf_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(rsp_push), .wdata(ds_rsp_data),
    .pop(pop), .flush(flush), .rdata(m_data), .count(fifo_count)
  );

  assign m_valid   = (fifo_count != '0);
  assign m_be      = be_w;
  assign ds_req_be = be_w;
  assign m_last    = m_valid && issue_done && (fifo_count == FW'(1));

  // R8: nothing of an ended transaction is visible afterwards
  a_r8_no_data_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_end && txn_active) |=> !m_valid);
endmodule

// File: tb/rdpf_bridge_tb_top.sv
`timescale 1ns/1ps
module rdpf_bridge_tb_top;
  localparam int AW = 30, DW = 32, DEPTH = 8, MAXL = 4, EXTRA = 1, LW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rd_strobe = 1'b0, txn_end = 1'b0;
  logic [1:0] req_cmd = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_be = 4'h0;
  logic [LW-1:0] cfg_line_log2 = '0;
  logic m_valid, m_last, ds_req_valid, ds_req_ready, ds_rsp_valid;
  logic [DW-1:0] m_data, ds_rsp_data;
  logic [3:0] m_be, ds_req_be;
  logic [AW-1:0] ds_req_addr;

  always #10 clk = ~clk;  // 50 MHz

  rdpf_bridge #(.AW(AW), .DATA_W(DW), .DEPTH(DEPTH), .MAX_LINE_LOG2(MAXL),
                .MULTI_EXTRA_LINES(EXTRA)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_be(req_be), .rd_strobe(rd_strobe), .txn_end(txn_end),
    .cfg_line_log2(cfg_line_log2), .m_valid(m_valid), .m_data(m_data), .m_be(m_be),
    .m_last(m_last), .ds_req_valid(ds_req_valid), .ds_req_ready(ds_req_ready),
    .ds_req_addr(ds_req_addr), .ds_req_be(ds_req_be), .ds_rsp_valid(ds_rsp_valid),
    .ds_rsp_data(ds_rsp_data));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] memf(input int a, input int ep);
    return {ep[7:0], a[23:0]};
  endfunction

  // downstream model and reference state
  int cyc = 0, lat = 2, ready_mode = 0, epoch = 0, txn_id = 0;
  int pend_addr[$], pend_due[$], pend_tag[$];
  bit m_act = 0, m_unb = 0, m_single = 0, stale_phase = 0;
  int m_next = 0, m_rem = 0, m_lim = 0, m_issued = 0, m_cons = 0, m_recv = 0;
  int m_total = 0, m_cons_addr = 0;
  logic [3:0] m_be_exp = 4'h0;

  always @(negedge clk) begin
    if (rst_n) begin
      ds_req_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      if (pend_due.size() > 0 && pend_due[0] <= cyc) begin
        ds_rsp_valid = 1'b1;
        ds_rsp_data  = memf(pend_addr[0], epoch);
      end else begin
        ds_rsp_valid = 1'b0;
        ds_rsp_data  = '0;
      end
    end else begin
      ds_req_ready = 1'b0;
      ds_rsp_valid = 1'b0;
      ds_rsp_data  = '0;
    end
    #5;
    if (rst_n) begin
      bit exp_dv, exp_mv;
      exp_dv = m_act && (m_unb || m_rem > 0) && ((m_issued - m_cons) < m_lim);
      exp_mv = m_act && (m_recv > m_cons);
      chk(ds_req_valid == exp_dv, m_act ? "R6" : "R8", "ds_req_valid", ds_req_valid, exp_dv);
      chk(m_valid == exp_mv, m_act ? "R7" : "R8", "m_valid", m_valid, exp_mv);
      chk(m_last == (exp_mv && !m_unb && m_cons == m_total - 1), m_single ? "R2" : "R3",
          "m_last", m_last, exp_mv && !m_unb && m_cons == m_total - 1);
      if (m_valid && exp_mv) begin
        chk(m_data == memf(m_cons_addr, epoch), stale_phase ? "R9" : "R7", "m_data",
            m_data, memf(m_cons_addr, epoch));
        chk(m_be == m_be_exp, m_single ? "R1" : "R5", "m_be", m_be, m_be_exp);
      end
      // response arrival
      if (ds_rsp_valid) begin
        if (pend_tag[0] == txn_id && m_act) m_recv++;
        void'(pend_addr.pop_front()); void'(pend_due.pop_front()); void'(pend_tag.pop_front());
      end
      // request handshake
      if (ds_req_valid && ds_req_ready) begin
        chk(int'(ds_req_addr) == m_next, m_unb ? "R4" : "R3", "ds_req_addr", ds_req_addr, m_next);
        chk(ds_req_be == m_be_exp, m_single ? "R1" : "R5", "ds_req_be", ds_req_be, m_be_exp);
        pend_addr.push_back(int'(ds_req_addr));
        pend_due.push_back(cyc + lat);
        pend_tag.push_back(txn_id);
        m_next++; m_issued++;
        if (!m_unb) m_rem--;
      end
      if (rd_strobe && m_valid) begin m_cons++; m_cons_addr++; end
      if (req_valid && !m_act && req_cmd != 2'b11) begin
        int line;
        line = 1 << ((int'(cfg_line_log2) > MAXL) ? MAXL : int'(cfg_line_log2));
        txn_id++;
        m_act = 1; m_unb = (req_cmd == 2'b10); m_single = (req_cmd == 2'b00);
        m_next = int'(req_addr); m_cons_addr = int'(req_addr);
        m_issued = 0; m_cons = 0; m_recv = 0;
        m_rem = m_single ? 1 : (line - (int'(req_addr) % line));
        m_total = m_rem;
        m_be_exp = m_single ? req_be : 4'hF;
        m_lim = (m_unb && line * (1 + EXTRA) < DEPTH) ? line * (1 + EXTRA) : DEPTH;
      end else if (txn_end && m_act) begin
        m_act = 0;
      end
      cyc++;
    end
  end

  task automatic start_txn(input logic [1:0] cmd, input int a, input logic [3:0] be,
                           input int cfg);
    @(negedge clk);
    epoch++;
    cfg_line_log2 = LW'(cfg);
    req_cmd = cmd; req_addr = AW'(a); req_be = be; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic read_n(input int n, input string req);
    int got = 0, w = 0;
    while (got < n && w < 400) begin
      @(negedge clk); rd_strobe = 1'b1; #5;
      if (m_valid) got++;
      w++;
    end
    @(negedge clk); rd_strobe = 1'b0;
    chk(got == n, req, "DWORDs delivered", got, n);
  endtask

  task automatic end_txn();
    @(negedge clk); txn_end = 1'b1;
    @(negedge clk); txn_end = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(4);
    #5;
    chk(!m_valid && !m_last && !ds_req_valid, "R10", "outputs in reset",
        {m_valid, m_last, ds_req_valid}, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(1); #5;
    chk(!m_valid && !ds_req_valid, "R10", "outputs after reset", {m_valid, ds_req_valid}, 0);

    // R1 R2: single read with partial enables
    start_txn(2'b00, 'h100, 4'b0110, 2);
    read_n(1, "R1");
    idle(6);
    chk(m_issued == 1, "R2", "single read fetch count", m_issued, 1);
    end_txn();

    // R3: line read starting at DWORD 1 of a 4-DWORD line
    start_txn(2'b01, 'h201, 4'b0001, 2);
    read_n(3, "R3");
    idle(5);
    chk(m_issued == 3, "R3", "mid-line fetch count", m_issued, 3);
    end_txn();

    // R6: 16-DWORD line against an 8-entry buffer, slow master
    start_txn(2'b01, 'h300, 4'b1111, 4);
    idle(20);
    chk(m_issued == DEPTH, "R6", "issue stalls at depth", m_issued, DEPTH);
    read_n(16, "R6");
    chk(m_issued == 16, "R6", "issue resumes to line end", m_issued, 16);
    end_txn();

    // R4: multiple read, 2-DWORD line gives a window of 4
    start_txn(2'b10, 'h401, 4'b0011, 1);
    idle(15);
    chk(m_issued == 4, "R4", "window below depth", m_issued, 4);
    read_n(10, "R4");
    chk(m_issued >= 10, "R4", "streams past line", m_issued, 10);
    end_txn();

    // R4 R5: multiple read with ready gaps and longer latency
    ready_mode = 1; lat = 5;
    start_txn(2'b10, 'h480, 4'b0000, 2);
    read_n(20, "R5");
    end_txn();
    ready_mode = 0;

    // R9: end with responses in flight, re-read the same addresses
    lat = 6;
    start_txn(2'b10, 'h500, 4'b1111, 2);
    read_n(1, "R9");
    end_txn();
    stale_phase = 1;
    start_txn(2'b01, 'h500, 4'b1111, 2);
    read_n(4, "R9");
    end_txn();
    stale_phase = 0; lat = 2;

    // R11: second request while open is ignored
    start_txn(2'b01, 'h600, 4'b1111, 3);
    idle(2);
    @(negedge clk); req_cmd = 2'b10; req_addr = AW'('h700); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    read_n(8, "R11");
    idle(4);
    chk(m_issued == 8 && m_next == 'h608, "R11", "fetch unaffected", m_next, 'h608);
    end_txn();

    // R12: reserved command, stray end
    start_txn(2'b11, 'h800, 4'b1111, 2);
    idle(4); #5;
    chk(!ds_req_valid && !m_valid, "R12", "reserved starts nothing", {ds_req_valid, m_valid}, 0);
    end_txn();
    start_txn(2'b00, 'h810, 4'b1000, 2);
    read_n(1, "R12");
    end_txn();

    // R8: end with data left in the buffer
    start_txn(2'b01, 'h900, 4'b1111, 3);
    read_n(2, "R8");
    idle(10);
    @(negedge clk); txn_end = 1'b1;
    @(negedge clk); txn_end = 1'b0; #5;
    chk(!m_valid && !ds_req_valid, "R8", "buffer dropped at end", {m_valid, ds_req_valid}, 0);
    idle(10);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule